// File: doc/BRIEF.md
# Dual-Direction Buffered Bus Bridge

This block links two 9-bit buses, A and B, through two independent first-in first-out stores. One store carries words from A toward B and the other carries words from B toward A. Each store has its own reset, its own load clock and its own unload clock, and any of these clocks may be asynchronous to the others. Read and write positions cross between the two clock domains as Gray code through two-flop synchronizers.

On each destination bus an enable decides whether the bus is driven. A select decides what is driven: either the live word on the opposite bus, or the word held in that direction's unload register. Both sources are stable when the select changes, so the switch never shows a value that is neither of them. Tri-state buses are modelled as a data vector plus an output enable.

The load side works like a stream. A word is offered with a valid strobe, and the full flag is its back-pressure: the word is taken on a load-clock edge where valid is high and full is low. A word offered while full is dropped, so a producer holds its word until full falls. On the unload side a request strobe pops the head on an unload-clock edge where empty is low. A request made while empty does nothing.

Top module: `bfx_xfer_top`

## Requirements
- R1: While a store's reset is high, and after it falls, that store shows empty=1, full=0, half=0 and almost=1. Its unload register reads 0.
- R2: Words leave each store in the order they were taken, with no loss and no duplicates. This holds with load and unload clocks that are unrelated to each other.
- R3: Empty is computed in the unload clock domain. An unload request while empty is ignored, and the unload register keeps its value.
- R4: Full is asserted when 1024 words are stored. A word offered while full is dropped and does not move the write position.
- R5: Half is high when the stored count is 513 or more, and low when it is 512 or less.
- R6: Almost is high when the count is at most T or at least 1024−T. T defaults to 8, so almost is high at counts 8 and 1016 and low at counts 9 and 1015.
- R7: The destination bus enable (b_oe, a_oe) follows its direction's enable input. With select=0 the destination data equals the opposite bus input (b_out = a_in, a_out = b_in).
- R8: With select=1 the destination data is the unload register. This register takes the head word on the unload-clock edge that accepts a request.
- R9: A load-clock edge where reset is high and valid is high copies the load data into T. A load-clock edge where reset is high and valid is low sets T to 8. Outside reset, T is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ab | input | 1 | Reset of the A-to-B store, active high |
| ab_ld_clk | input | 1 | Load clock, A-to-B |
| ab_ul_clk | input | 1 | Unload clock, A-to-B |
| a_in | input | 9 | Bus A input word |
| ab_ld_valid | input | 1 | Offer a_in to the A-to-B store |
| ab_full | output | 1 | A-to-B full, load domain |
| ab_half | output | 1 | A-to-B at least 513 words |
| ab_almost | output | 1 | A-to-B within T of either end |
| ab_ul_req | input | 1 | Pop the A-to-B head |
| ab_empty | output | 1 | A-to-B empty, unload domain |
| ab_en | input | 1 | Drive bus B |
| ab_sel | input | 1 | 0 live bus A, 1 stored word |
| b_out | output | 9 | Data driven onto bus B |
| b_oe | output | 1 | Bus B output enable |
| rst_ba | input | 1 | Reset of the B-to-A store, active high |
| ba_ld_clk | input | 1 | Load clock, B-to-A |
| ba_ul_clk | input | 1 | Unload clock, B-to-A |
| b_in | input | 9 | Bus B input word |
| ba_ld_valid | input | 1 | Offer b_in to the B-to-A store |
| ba_full | output | 1 | B-to-A full |
| ba_half | output | 1 | B-to-A at least 513 words |
| ba_almost | output | 1 | B-to-A within T of either end |
| ba_ul_req | input | 1 | Pop the B-to-A head |
| ba_empty | output | 1 | B-to-A empty |
| ba_en | input | 1 | Drive bus A |
| ba_sel | input | 1 | 0 live bus B, 1 stored word |
| a_out | output | 9 | Data driven onto bus A |
| a_oe | output | 1 | Bus A output enable |

## Verification
The A-to-B store is filled one word at a time. This pins the flag thresholds to exact counts, 8/9 and 1015/1016 for almost, 512/513 for half and 1023/1024 for full. It also separates an off-by-one from a correct compare. Extra writes at full and extra pops at empty show whether a blocked access moves a position: after exactly 1024 pops the store must read empty, and the output must stay still. Random valid and request duty cycles on unrelated clocks exercise the Gray-code crossing, where a synchronizer fault shows up as reordered or repeated words. The B-to-A side, loaded with T=4 during reset, tells the loaded threshold apart from the default one. Toggling select and enable against random bus words separates the live path from the stored path.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
  localparam int unsigned BUS_W = 9;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/bfx_gray_sync.sv
`timescale 1ns/1ps
module bfx_gray_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/bfx_fifo_dir.sv
`timescale 1ns/1ps
module bfx_fifo_dir #(
  parameter int DW      = 9,
  parameter int DEPTH   = 1024,
  parameter int THR_DEF = 8
) (
  input  logic          rst,
  input  logic          ld_clk,
  input  logic          ld_valid,
  input  logic [DW-1:0] ld_data,
  output logic          full,
  output logic          half,
  output logic          almost,
  input  logic          ul_clk,
  input  logic          ul_req,
  output logic          empty,
  output logic [DW-1:0] head_q
);
  localparam int AW        = $clog2(DEPTH);
  localparam int PW        = AW + 1;
  localparam int HALF_MARK = DEPTH / 2 + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // load domain
  logic [PW-1:0] wbin_q, wgray_q, rgray_s, rbin_s, level;
  logic [DW-1:0] thr_q;
  logic [PW-1:0] thr_w;
  logic          push;

  bfx_gray_sync #(.W(PW)) u_rsync (
    .clk(ld_clk), .rst(rst), .d(rgray_q), .q(rgray_s)
  );

  assign rbin_s = from_gray(rgray_s);
  assign level  = wbin_q - rbin_s;
  assign full   = (wgray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
  assign push   = ld_valid && !full;
  assign thr_w  = PW'(thr_q);
  assign half   = (level >= PW'(HALF_MARK));
  assign almost = (level <= thr_w) || (level >= (PW'(DEPTH) - thr_w));

  always_ff @(posedge ld_clk or posedge rst) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= to_gray(wbin_q + 1'b1);
    end
  end

  always_ff @(posedge ld_clk) begin
    if (push) mem[wbin_q[AW-1:0]] <= ld_data;
  end

  // threshold capture while reset is high
  always_ff @(posedge ld_clk) begin
    if (rst) thr_q <= ld_valid ? ld_data : DW'(THR_DEF);
  end

  // unload domain
  logic [PW-1:0] rbin_q, rgray_q, wgray_s;
  logic          pop;

  bfx_gray_sync #(.W(PW)) u_wsync (
    .clk(ul_clk), .rst(rst), .d(wgray_q), .q(wgray_s)
  );

  assign empty = (rgray_q == wgray_s);
  assign pop   = ul_req && !empty;

  always_ff @(posedge ul_clk or posedge rst) begin
    if (rst) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      head_q  <= '0;
    end else if (pop) begin
      head_q  <= mem[rbin_q[AW-1:0]];
      rbin_q  <= rbin_q + 1'b1;
      rgray_q <= to_gray(rbin_q + 1'b1);
    end
  end
endmodule

// File: rtl/bfx_drive.sv
`timescale 1ns/1ps
module bfx_drive
  import bfx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          en,
  input  logic          sel,
  input  logic [DW-1:0] live,
  input  logic [DW-1:0] stored,
  output logic [DW-1:0] dout,
  output logic          oe
);
  src_e src;

  assign src = src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_STORED: dout = stored;
      default:    dout = live;
    endcase
  end

  assign oe = en;
endmodule

// File: rtl/bfx_xfer_top.sv
`timescale 1ns/1ps
module bfx_xfer_top
  import bfx_pkg::*;
#(
  parameter int WORD_W  = BUS_W,
  parameter int DEPTH   = 1024,
  parameter int THR_DEF = 8
) (
  input  logic              rst_ab,
  input  logic              ab_ld_clk,
  input  logic              ab_ul_clk,
  input  logic [WORD_W-1:0] a_in,
  input  logic              ab_ld_valid,
  output logic              ab_full,
  output logic              ab_half,
  output logic              ab_almost,
  input  logic              ab_ul_req,
  output logic              ab_empty,
  input  logic              ab_en,
  input  logic              ab_sel,
  output logic [WORD_W-1:0] b_out,
  output logic              b_oe,
  input  logic              rst_ba,
  input  logic              ba_ld_clk,
  input  logic              ba_ul_clk,
  input  logic [WORD_W-1:0] b_in,
  input  logic              ba_ld_valid,
  output logic              ba_full,
  output logic              ba_half,
  output logic              ba_almost,
  input  logic              ba_ul_req,
  output logic              ba_empty,
  input  logic              ba_en,
  input  logic              ba_sel,
  output logic [WORD_W-1:0] a_out,
  output logic              a_oe
);
  logic [WORD_W-1:0] ab_head, ba_head;

  bfx_fifo_dir #(.DW(WORD_W), .DEPTH(DEPTH), .THR_DEF(THR_DEF)) u_ab (
    .rst(rst_ab), .ld_clk(ab_ld_clk), .ld_valid(ab_ld_valid), .ld_data(a_in),
    .full(ab_full), .half(ab_half), .almost(ab_almost),
    .ul_clk(ab_ul_clk), .ul_req(ab_ul_req), .empty(ab_empty), .head_q(ab_head)
  );

  bfx_fifo_dir #(.DW(WORD_W), .DEPTH(DEPTH), .THR_DEF(THR_DEF)) u_ba (
    .rst(rst_ba), .ld_clk(ba_ld_clk), .ld_valid(ba_ld_valid), .ld_data(b_in),
    .full(ba_full), .half(ba_half), .almost(ba_almost),
    .ul_clk(ba_ul_clk), .ul_req(ba_ul_req), .empty(ba_empty), .head_q(ba_head)
  );

  bfx_drive #(.DW(WORD_W)) u_drv_b (
    .en(ab_en), .sel(ab_sel), .live(a_in), .stored(ab_head),
    .dout(b_out), .oe(b_oe)
  );

  bfx_drive #(.DW(WORD_W)) u_drv_a (
    .en(ba_en), .sel(ba_sel), .live(b_in), .stored(ba_head),
    .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/bfx_xfer_chk.sv
`timescale 1ns/1ps
module bfx_xfer_chk #(
  parameter int DW = 9
) (
  input logic          ld_clk,
  input logic          ul_clk,
  input logic          rst,
  input logic          ld_valid,
  input logic          full,
  input logic          half,
  input logic          almost,
  input logic          ul_req,
  input logic          empty,
  input logic          sel,
  input logic [DW-1:0] drv
);
  p_reset_empty_r1: assert property (@(posedge ul_clk) disable iff (rst)
    $fell(rst) |-> empty);

  p_full_flags_r5: assert property (@(posedge ld_clk) disable iff (rst)
    full |-> (half && almost));

  p_full_needs_write_r4: assert property (@(posedge ld_clk) disable iff (rst)
    $rose(full) |-> $past(ld_valid));

  p_empty_hold_r3: assert property (@(posedge ul_clk) disable iff (rst)
    (ul_req && empty && sel) |=> (sel -> $stable(drv)));
endmodule

bind bfx_xfer_top bfx_xfer_chk #(.DW(WORD_W)) u_chk_ab (
  .ld_clk(ab_ld_clk), .ul_clk(ab_ul_clk), .rst(rst_ab), .ld_valid(ab_ld_valid),
  .full(ab_full), .half(ab_half), .almost(ab_almost), .ul_req(ab_ul_req),
  .empty(ab_empty), .sel(ab_sel), .drv(b_out)
);

bind bfx_xfer_top bfx_xfer_chk #(.DW(WORD_W)) u_chk_ba (
  .ld_clk(ba_ld_clk), .ul_clk(ba_ul_clk), .rst(rst_ba), .ld_valid(ba_ld_valid),
  .full(ba_full), .half(ba_half), .almost(ba_almost), .ul_req(ba_ul_req),
  .empty(ba_empty), .sel(ba_sel), .drv(a_out)
);

// File: tb/bfx_xfer_top_bench.sv
`timescale 1ns/1ps
module bfx_xfer_top_bench;
  logic rst_ab = 1'b1, rst_ba = 1'b1;
  logic ab_ld_clk = 1'b0, ab_ul_clk = 1'b0, ba_ld_clk = 1'b0, ba_ul_clk = 1'b0;
  logic [8:0] a_in = '0, b_in = '0;
  logic ab_ld_valid = 1'b0, ba_ld_valid = 1'b0;
  logic ab_ul_req = 1'b0, ba_ul_req = 1'b0;
  logic ab_en = 1'b0, ab_sel = 1'b0, ba_en = 1'b0, ba_sel = 1'b0;
  logic ab_full, ab_half, ab_almost, ab_empty, b_oe;
  logic ba_full, ba_half, ba_almost, ba_empty, a_oe;
  logic [8:0] b_out, a_out;

  bfx_xfer_top u_bfx_xfer_top (.*);

  always #4   ab_ld_clk = ~ab_ld_clk;   // 125 MHz
  always #5   ab_ul_clk = ~ab_ul_clk;
  always #6   ba_ld_clk = ~ba_ld_clk;
  always #3.5 ba_ul_clk = ~ba_ul_clk;

  int total = 0, bad = 0;
  logic [8:0] q_ab[$], q_ba[$];
  logic [8:0] last_ab = '0, last_ba = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] rword();
    return 9'($urandom);
  endfunction

  task automatic push_ab(input int n, input int pct);
    bit pend = 0; logic [8:0] pd = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge ab_ld_clk);
      if (pend) q_ab.push_back(pd);
      ab_ld_valid = (($urandom % 100) < pct);
      a_in = rword();
      pend = ab_ld_valid && !ab_full; pd = a_in;
    end
    @(negedge ab_ld_clk);
    if (pend) q_ab.push_back(pd);
    ab_ld_valid = 1'b0;
  endtask

  task automatic push_ba(input int n, input int pct);
    bit pend = 0; logic [8:0] pd = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge ba_ld_clk);
      if (pend) q_ba.push_back(pd);
      ba_ld_valid = (($urandom % 100) < pct);
      b_in = rword();
      pend = ba_ld_valid && !ba_full; pd = b_in;
    end
    @(negedge ba_ld_clk);
    if (pend) q_ba.push_back(pd);
    ba_ld_valid = 1'b0;
  endtask

  // Pops with select=1, checking each popped word on b_out (R2, R8) and
  // that a request while empty leaves b_out alone (R3).
  task automatic pop_ab(input int n, input int pct);
    bit pend = 0, idle_req = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge ab_ul_clk);
      if (pend) begin
        if (q_ab.size() == 0) chk("R2 underrun", 1, 0);
        else begin last_ab = q_ab.pop_front(); chk("R2/R8 b_out", b_out, last_ab); end
      end else if (idle_req) chk("R3 b_out hold", b_out, last_ab);
      ab_ul_req = (i < n) && (($urandom % 100) < pct);
      pend = ab_ul_req && !ab_empty;
      idle_req = ab_ul_req && ab_empty;
    end
    ab_ul_req = 1'b0;
  endtask

  task automatic pop_ba(input int n, input int pct);
    bit pend = 0, idle_req = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge ba_ul_clk);
      if (pend) begin
        if (q_ba.size() == 0) chk("R2 underrun", 1, 0);
        else begin last_ba = q_ba.pop_front(); chk("R2/R8 a_out", a_out, last_ba); end
      end else if (idle_req) chk("R3 a_out hold", a_out, last_ba);
      ba_ul_req = (i < n) && (($urandom % 100) < pct);
      pend = ba_ul_req && !ba_empty;
      idle_req = ba_ul_req && ba_empty;
    end
    ba_ul_req = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge ab_ul_clk);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0bf1));
    // R9: load T=4 into the B-to-A store during reset
    ba_ld_valid = 1'b1; b_in = 9'd4;
    repeat (6) @(negedge ab_ld_clk);
    rst_ab = 1'b0;
    repeat (4) @(negedge ba_ld_clk);
    rst_ba = 1'b0; ba_ld_valid = 1'b0;
    settle();

    // R1 reset state
    chk("R1 ab_empty", ab_empty, 1); chk("R1 ab_full", ab_full, 0);
    chk("R1 ab_half", ab_half, 0);   chk("R1 ab_almost", ab_almost, 1);
    chk("R1 ba_empty", ba_empty, 1); chk("R1 ba_almost", ba_almost, 1);
    ab_sel = 1'b1; ab_en = 1'b1; #1;
    chk("R1 stored zero", b_out, 0);

    // directed fill of A-to-B, one word at a time
    for (int k = 1; k <= 1024; k++) begin
      push_ab(1, 100);
      if (k == 8)    chk("R6 almost@8", ab_almost, 1);
      if (k == 9)    chk("R6 almost@9", ab_almost, 0);
      if (k == 512)  chk("R5 half@512", ab_half, 0);
      if (k == 513)  chk("R5 half@513", ab_half, 1);
      if (k == 1015) chk("R6 almost@1015", ab_almost, 0);
      if (k == 1016) chk("R6 almost@1016", ab_almost, 1);
      if (k == 1023) chk("R4 full@1023", ab_full, 0);
      if (k == 1024) chk("R4 full@1024", ab_full, 1);
    end
    push_ab(3, 100);                          // R4: dropped while full
    chk("R4 still full", ab_full, 1);
    chk("R4 model count", q_ab.size(), 1024);
    settle();
    pop_ab(1024, 100);
    chk("R4 exactly 1024 stored", ab_empty, 1);
    pop_ab(3, 100);                           // R3: pops while empty
    chk("R3 empty stays", ab_empty, 1);
    chk("R3 out unchanged", b_out, last_ab);

    // R7 live path and enable
    ab_sel = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge ab_ld_clk); a_in = rword(); ab_en = i[0]; #1;
      chk("R7 live b_out", b_out, a_in);
      chk("R7 b_oe", b_oe, ab_en);
    end
    ab_sel = 1'b1; #1;
    chk("R8 back to stored", b_out, last_ab);
    ab_en = 1'b1;

    // random concurrent traffic A-to-B
    fork
      push_ab(500, 60);
      begin settle(); pop_ab(450, 55); end
    join
    settle();
    while (q_ab.size() > 0) begin pop_ab(q_ab.size(), 100); settle(); end
    chk("R2 drained empty", ab_empty, 1);

    // B-to-A with the loaded threshold T=4
    ba_sel = 1'b1; ba_en = 1'b1;
    push_ba(4, 100); settle();
    chk("R9 almost@4", ba_almost, 1);
    push_ba(1, 100); settle();
    chk("R9 almost@5", ba_almost, 0);
    chk("R5 ba_half low", ba_half, 0);
    fork
      push_ba(200, 70);
      pop_ba(200, 50);
    join
    settle();
    while (q_ba.size() > 0) begin pop_ba(q_ba.size(), 100); settle(); end
    chk("R2 ba drained", ba_empty, 1);
    ba_sel = 1'b0; @(negedge ba_ld_clk); b_in = 9'h1a5; #1;
    chk("R7 live a_out", a_out, 9'h1a5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule